// File: doc/BRIEF.md
# Supply-Fail Access Gate

This block sits between the asynchronous control pins of a byte-wide static memory and the memory core. It turns two chip enables, an output enable and a write enable into clean read, write and bus-drive strobes in the core clock domain. It also holds off all access while the supply is low and for a set time after the supply comes back.

Supply state arrives as two digitised comparator flags. One says the supply is above the deselect threshold. The other says it is above the lower battery switchover threshold. Every pin and flag passes through a synchroniser. A single-cycle millisecond tick, synchronous to the clock, paces the recovery timer. The timer counts `RECOV_MS` ticks after the supply returns. A write that is cut off by a supply failure is not resumed: the host has to release the write condition and assert it again. The battery-select output follows the lower threshold flag.

Top module: `pfg_gate`

## Requirements
- R1: `rd_o` is high when `we_n_i`=1, `ce1_n_i`=0 and `ce2_i`=1 and protection is off, and low otherwise.
- R2: `dq_oe_o` is high only while a read is active and `oe_n_i`=0. Driving `we_n_i` low during an enabled read turns `dq_oe_o` off.
- R3: `wr_o` is high when `we_n_i`=0, `ce1_n_i`=0 and `ce2_i`=1 and protection is off. It drops as soon as any one of those three terms is removed.
- R4: While `vok_i`=0, `prot_o` is high and `rd_o`, `wr_o` and `dq_oe_o` stay low whatever the control pins do.
- R5: `bat_sel_o` is the inverse of `vbat_ok_i`. It asserts while the supply is below the switchover threshold and clears when the supply rises above it again.
- R6: After `vok_i` returns high, `prot_o` stays high until exactly `RECOV_MS` ticks (default 40) have been seen with the supply good. It clears after the last of those ticks.
- R7: If `vok_i` drops during recovery, the tick count restarts from zero, and a full `RECOV_MS` ticks are needed once the supply is good again.
- R8: A write active when protection asserts is ended at once. Once protection clears, `wr_o` stays low until the write condition has been released and asserted again.
- R9: A change on any control pin or supply flag reaches the outputs on the third rising clock edge after it: two synchroniser stages and one output register.
- R10: After reset, `rd_o`, `wr_o`, `dq_oe_o` and `bat_sel_o` are low and `prot_o` is high. A full recovery period is needed before any access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce1_n_i | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| vok_i | input | 1 | Supply above the deselect threshold |
| vbat_ok_i | input | 1 | Supply above the battery switchover threshold |
| ms_tick_i | input | 1 | One-cycle millisecond tick |
| rd_o | output | 1 | Read access strobe |
| wr_o | output | 1 | Write access strobe |
| dq_oe_o | output | 1 | Data bus output enable |
| bat_sel_o | output | 1 | Battery supply select |
| prot_o | output | 1 | Protection (deselect and write protect) active |

## Verification
The hardest case to reach is a write cut off by a supply failure that is followed by a complete recovery while the write pins are still held asserted. Only that sequence shows whether the blocked write comes back by itself. The bench holds the write condition, drops the supply flag, then raises it and delivers all recovery ticks before releasing the pins. A second sequence drops the supply partway through the tick count, then checks that one tick short of a fresh full count still leaves the gate protected.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  localparam int unsigned NUM_IN = 6;
  // raw input vector layout
  localparam int unsigned IX_CE1N = 0;
  localparam int unsigned IX_CE2  = 1;
  localparam int unsigned IX_OEN  = 2;
  localparam int unsigned IX_WEN  = 3;
  localparam int unsigned IX_VOK  = 4;
  localparam int unsigned IX_VBAT = 5;
  // idle/unsafe values held in the synchroniser during reset
  localparam logic [NUM_IN-1:0] IN_RST = 6'b10_1101;

  typedef struct packed {
    logic we_n;
    logic oe_n;
    logic ce2;
    logic ce1_n;
  } ctl_t;
endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_st
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st[g] <= RST_VAL;
        else         st[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st[g] <= RST_VAL;
        else         st[g] <= st[g-1];
      end
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/pfg_recovery.sv
module pfg_recovery #(
  parameter int unsigned RECOV_MS = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vok_i,
  input  logic tick_i,
  output logic prot_o
);
  localparam int unsigned CNT_W = $clog2(RECOV_MS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RECOV_MS);

  logic [CNT_W-1:0] cnt_q;

  // reload while supply is bad, count down ticks once it is good
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= CNT_LOAD;
    else if (!vok_i)               cnt_q <= CNT_LOAD;
    else if (tick_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign prot_o = !vok_i || (cnt_q != '0);

  p_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vok_i |=> cnt_q == CNT_LOAD);
  p_no_up_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vok_i |=> cnt_q <= $past(cnt_q));
  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vok_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pfg_access.sv
module pfg_access
  import pfg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  ctl_t ctl_i,
  input  logic prot_i,
  output logic rd_o,
  output logic wr_o,
  output logic dq_oe_o
);
  logic sel, rd_cond, wr_cond;
  logic wr_blk_q, wr_blk_d;
  logic rd_d, wr_d, oe_d;

  assign sel     = !ctl_i.ce1_n && ctl_i.ce2;
  assign rd_cond = sel && ctl_i.we_n;
  assign wr_cond = sel && !ctl_i.we_n;

  // a write cut by protection stays blocked until the host releases it
  always_comb begin
    wr_blk_d = wr_blk_q;
    if (!wr_cond)    wr_blk_d = 1'b0;
    else if (prot_i) wr_blk_d = 1'b1;
  end

  assign rd_d = rd_cond && !prot_i;
  assign wr_d = wr_cond && !prot_i && !wr_blk_q;
  assign oe_d = rd_d && !ctl_i.oe_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_blk_q <= 1'b0;
      rd_o     <= 1'b0;
      wr_o     <= 1'b0;
      dq_oe_o  <= 1'b0;
    end else begin
      wr_blk_q <= wr_blk_d;
      rd_o     <= rd_d;
      wr_o     <= wr_d;
      dq_oe_o  <= oe_d;
    end
  end

  p_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  p_oe_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> rd_o);
  p_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_i |=> !wr_o && !rd_o);
  p_no_resume_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_blk_q && wr_cond) |=> !wr_o);
endmodule

// File: rtl/pfg_gate.sv
module pfg_gate
  import pfg_pkg::*;
#(
  parameter int unsigned RECOV_MS    = 40,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce1_n_i,
  input  logic ce2_i,
  input  logic oe_n_i,
  input  logic we_n_i,
  input  logic vok_i,
  input  logic vbat_ok_i,
  input  logic ms_tick_i,
  output logic rd_o,
  output logic wr_o,
  output logic dq_oe_o,
  output logic bat_sel_o,
  output logic prot_o
);
  logic [NUM_IN-1:0] raw, syn;
  ctl_t ctl;
  logic prot;

  assign raw[IX_CE1N] = ce1_n_i;
  assign raw[IX_CE2]  = ce2_i;
  assign raw[IX_OEN]  = oe_n_i;
  assign raw[IX_WEN]  = we_n_i;
  assign raw[IX_VOK]  = vok_i;
  assign raw[IX_VBAT] = vbat_ok_i;

  pfg_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  assign ctl.ce1_n = syn[IX_CE1N];
  assign ctl.ce2   = syn[IX_CE2];
  assign ctl.oe_n  = syn[IX_OEN];
  assign ctl.we_n  = syn[IX_WEN];

  pfg_recovery #(.RECOV_MS(RECOV_MS)) u_recov (
    .clk_i(clk_i), .rst_ni(rst_ni), .vok_i(syn[IX_VOK]),
    .tick_i(ms_tick_i), .prot_o(prot)
  );

  pfg_access u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctl_i(ctl), .prot_i(prot),
    .rd_o(rd_o), .wr_o(wr_o), .dq_oe_o(dq_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_o    <= 1'b1;
      bat_sel_o <= 1'b0;
    end else begin
      prot_o    <= prot;
      bat_sel_o <= !syn[IX_VBAT];
    end
  end

  p_desel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !syn[IX_VOK] |=> prot_o && !wr_o && !rd_o && !dq_oe_o);
  p_bat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(syn[IX_VBAT]) |=> bat_sel_o);
  p_strobe_free_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) |-> !prot_o);
endmodule

// File: tb/pfg_gate_tb.sv
module pfg_gate_tb;
  localparam int unsigned RECOV = 40;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ce1_n = 1'b1, ce2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic vok = 1'b0, vbat_ok = 1'b1, tick = 1'b0;
  logic rd, wr, dq_oe, bat_sel, prot;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  pfg_gate #(.RECOV_MS(RECOV)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ce1_n_i(ce1_n), .ce2_i(ce2),
    .oe_n_i(oe_n), .we_n_i(we_n), .vok_i(vok), .vbat_ok_i(vbat_ok),
    .ms_tick_i(tick), .rd_o(rd), .wr_o(wr), .dq_oe_o(dq_oe),
    .bat_sel_o(bat_sel), .prot_o(prot)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; step(1);
      tick = 1'b0; step(1);
    end
  endtask

  task automatic recover();
    vok = 1'b1; step(4);
    pulse_ticks(RECOV);
    step(4);
  endtask

  task automatic idle_pins();
    ce1_n = 1'b1; ce2 = 1'b0; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic t_reset();
    vok = 1'b1;
    step(6);
    chk("R10 rd", rd, 1'b0);
    chk("R10 wr", wr, 1'b0);
    chk("R10 oe", dq_oe, 1'b0);
    chk("R10 bat", bat_sel, 1'b0);
    chk("R10 prot", prot, 1'b1);
  endtask

  task automatic t_recovery();
    pulse_ticks(RECOV - 1);
    step(4);
    chk("R6 prot one tick short", prot, 1'b1);
    pulse_ticks(1);
    step(3);
    chk("R6 prot after last tick", prot, 1'b0);
  endtask

  task automatic t_read();
    ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    step(2);
    chk("R9 rd not before third edge", rd, 1'b0);
    step(1);
    chk("R9 rd at third edge", rd, 1'b1);
    chk("R2 oe off with oe_n high", dq_oe, 1'b0);
    oe_n = 1'b0; step(4);
    chk("R2 oe on", dq_oe, 1'b1);
    ce2 = 1'b0; step(4);
    chk("R1 rd off ce2 low", rd, 1'b0);
    chk("R2 oe off ce2 low", dq_oe, 1'b0);
    ce2 = 1'b1; ce1_n = 1'b1; step(4);
    chk("R1 rd off ce1_n high", rd, 1'b0);
    ce1_n = 1'b0; step(4);
    chk("R1 rd back", rd, 1'b1);
  endtask

  task automatic t_write();
    we_n = 1'b0; step(4);
    chk("R2 oe off when we_n falls", dq_oe, 1'b0);
    chk("R3 wr on", wr, 1'b1);
    chk("R1 rd off during write", rd, 1'b0);
    ce1_n = 1'b1; step(4);
    chk("R3 wr ends ce1_n", wr, 1'b0);
    ce1_n = 1'b0; step(4);
    chk("R3 wr again", wr, 1'b1);
    we_n = 1'b1; step(4);
    chk("R3 wr ends we_n", wr, 1'b0);
    idle_pins(); step(4);
  endtask

  task automatic t_deselect();
    ce1_n = 1'b0; ce2 = 1'b1; oe_n = 1'b0; we_n = 1'b1;
    step(4);
    vok = 1'b0; step(4);
    chk("R4 prot", prot, 1'b1);
    chk("R4 rd", rd, 1'b0);
    chk("R4 oe", dq_oe, 1'b0);
    we_n = 1'b0; step(4);
    chk("R4 wr ignored", wr, 1'b0);
    idle_pins();
    recover();
    chk("R4 free again", prot, 1'b0);
  endtask

  task automatic t_abort();
    ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b0; step(4);
    chk("R8 write running", wr, 1'b1);
    vok = 1'b0; step(3);
    chk("R8 write aborted", wr, 1'b0);
    recover();
    chk("R8 prot cleared", prot, 1'b0);
    chk("R8 no resume", wr, 1'b0);
    we_n = 1'b1; step(4);
    we_n = 1'b0; step(4);
    chk("R8 fresh write", wr, 1'b1);
    idle_pins(); step(4);
  endtask

  task automatic t_dip();
    vok = 1'b0; step(4);
    vok = 1'b1; step(4);
    pulse_ticks(20);
    vok = 1'b0; step(4);
    pulse_ticks(5);
    vok = 1'b1; step(4);
    pulse_ticks(RECOV - 1);
    step(4);
    chk("R7 still protected after restart", prot, 1'b1);
    pulse_ticks(1);
    step(3);
    chk("R7 free after full count", prot, 1'b0);
  endtask

  task automatic t_battery();
    vok = 1'b0; vbat_ok = 1'b0; step(4);
    chk("R5 bat on", bat_sel, 1'b1);
    vbat_ok = 1'b1; step(4);
    chk("R5 bat off", bat_sel, 1'b0);
    chk("R5 still protected", prot, 1'b1);
    recover();
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    t_reset();
    t_recovery();
    t_read();
    t_write();
    t_deselect();
    t_abort();
    t_dip();
    t_battery();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule